// File: doc/BRIEF.md
# Ping-Loss Watchdog with Automatic Escalation

This block sits at the receiving end of one escalation channel and watches the liveness pings that a remote sender issues on that channel. It stays unarmed after reset and ignores the passage of time until the first ping strobe arrives. From then on a cycle counter measures the time since the most recent ping. Every ping restarts the counter from zero. If a full window of `THRESH` cycles goes by with no ping, the block raises its escalation output by itself, as if a genuine escalation had been requested, and holds it until reset.

The sender walks its channels one at a time in a fixed rotation, so there is a guaranteed upper bound on the spacing between two pings on any one channel: `NUM_CH * (WAIT_COUNTS + TIMEOUT_COUNTS) * 2**CNT_W` cycles. The window is `MARGIN` times that bound, and `MARGIN` defaults to 4. With the default parameters the window is 2**22 cycles, and the counter is 22 bits wide. Each received ping is acknowledged by a one-cycle pulse. A genuine escalation request passes straight through to the output in the same cycle.

The control is a three-state machine. `WD_IDLE` is the reset state, in which the block is unarmed. The transition *arm* (a ping strobe) leads to `WD_ARMED`, in which the block is monitoring. The transition *timeout* (the counter reaches the last cycle of the window) leads to `WD_FIRED`, the terminal state that latches the escalation. Only reset leaves `WD_FIRED`.

Top module: `ping_loss_watchdog`

## Requirements
- R1: After reset `esc_active_o` and `ping_ack_o` are 0. While no ping has been received, `esc_active_o` follows only `esc_req_i`, however long the block waits.
- R2: The first ping strobe arms the monitor. The window of that ping starts on the clock edge that samples it.
- R3: Each ping sampled while armed restarts the window. With the last ping sampled on edge k, no automatic escalation occurs through edge k+THRESH-1.
- R4: If the last ping was sampled on edge k and none follows, `esc_active_o` rises right after edge k+THRESH. A ping on edge k+THRESH-1 prevents this. A ping on edge k+THRESH itself is too late.
- R5: Once raised by a timeout, `esc_active_o` stays 1 until reset. Further pings and changes of `esc_req_i` leave it at 1. The counter stops instead of wrapping.
- R6: A ping strobe sampled on an edge makes `ping_ack_o` 1 for exactly the following cycle. Strobes on consecutive edges give a continuous acknowledge. The acknowledge also works after escalation.
- R7: `esc_req_i` = 1 drives `esc_active_o` to 1 in the same cycle, armed or not. Releasing it drops the output unless a timeout has latched.
- R8: THRESH = MARGIN * NUM_CH * (WAIT_COUNTS + TIMEOUT_COUNTS) * 2**CNT_W. The counter has $clog2(THRESH) bits, which is 22 with the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ping_strobe_i | input | 1 | Ping received on the monitored channel, one strobe per cycle high |
| esc_req_i | input | 1 | Genuine escalation request |
| esc_active_o | output | 1 | Escalation active |
| ping_ack_o | output | 1 | One-cycle acknowledge of a received ping |

## Verification
The bench builds the block with NUM_CH=1, CNT_W=2, WAIT_COUNTS=1, TIMEOUT_COUNTS=1 and MARGIN=2, which gives a window of 16 cycles. With so short a window, the bench can sweep every ping spacing from 1 to the full window. For each spacing it checks the escalation output on every cycle past the expected firing edge. This covers the rescue one cycle before expiry and the late ping on the expiry edge itself. The same small window lets the bench cover the never-pinged case, regular pinging, the sticky behaviour and the pass-through request within a few thousand cycles.

// File: rtl/ping_loss_watchdog_pkg.sv
`timescale 1ns/1ps
package ping_loss_watchdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'b00,
        WD_ARMED = 2'b01,
        WD_FIRED = 2'b10
    } wd_state_e;

endpackage

// File: rtl/pl_wdog_timer.sv
`timescale 1ns/1ps
module pl_wdog_timer #(
    parameter int unsigned THRESH = 16,
    parameter int unsigned TMR_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic expire_o
);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(THRESH - 1);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);

    // R3: a ping leaves the counter at zero on the next cycle
    assert_ping_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

    // R5: the counter never passes the last window cycle
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/pl_wdog_fsm.sv
`timescale 1ns/1ps
module pl_wdog_fsm
    import ping_loss_watchdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ping_i,
    input  logic expire_i,
    output logic run_o,
    output logic fired_o
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (ping_i)   state_d = WD_ARMED;
            WD_ARMED: if (expire_i) state_d = WD_FIRED;
            WD_FIRED: state_d = WD_FIRED;
            default:  state_d = WD_FIRED;
        endcase
    end

    always_comb begin
        run_o   = 1'b0;
        fired_o = 1'b0;
        unique case (state_q)
            WD_IDLE:  ;
            WD_ARMED: run_o = 1'b1;
            WD_FIRED: fired_o = 1'b1;
            default:  fired_o = 1'b1;
        endcase
    end

    // R1: an unarmed monitor never jumps straight to escalation
    assert_idle_no_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IDLE) |=> (state_q != WD_FIRED));

    // R2: a ping seen while unarmed arms the monitor
    assert_first_ping_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WD_IDLE) && ping_i) |=> (state_q == WD_ARMED));

    // R4: expiry while armed latches escalation
    assert_expire_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WD_ARMED) && expire_i) |=> (state_q == WD_FIRED));

    // R5: the fired state is terminal
    assert_fired_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRED) |=> (state_q == WD_FIRED));

endmodule

// File: rtl/pl_wdog_ack.sv
`timescale 1ns/1ps
module pl_wdog_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic ping_i,
    output logic ack_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
        end else begin
            ack_o <= ping_i;
        end
    end
endmodule

// File: rtl/ping_loss_watchdog.sv
`timescale 1ns/1ps
module ping_loss_watchdog #(
    parameter int unsigned NUM_CH         = 4,
    parameter int unsigned CNT_W          = 16,
    parameter int unsigned WAIT_COUNTS    = 2,
    parameter int unsigned TIMEOUT_COUNTS = 2,
    parameter int unsigned MARGIN         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ping_strobe_i,
    input  logic esc_req_i,
    output logic esc_active_o,
    output logic ping_ack_o
);
    // R8: window derived from the sender's worst-case spacing
    localparam int unsigned THRESH = MARGIN * NUM_CH * (WAIT_COUNTS + TIMEOUT_COUNTS) * (2 ** CNT_W);
    localparam int unsigned TMR_W  = $clog2(THRESH);

    logic run, fired, expire;

    pl_wdog_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ping_i   (ping_strobe_i),
        .expire_i (expire),
        .run_o    (run),
        .fired_o  (fired)
    );

    pl_wdog_timer #(
        .THRESH (THRESH),
        .TMR_W  (TMR_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ping_strobe_i),
        .run_i     (run),
        .expire_o  (expire)
    );

    pl_wdog_ack u_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .ping_i (ping_strobe_i),
        .ack_o  (ping_ack_o)
    );

    assign esc_active_o = fired | esc_req_i;

    // R6: acknowledge follows each strobe by one cycle
    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ping_strobe_i |=> ping_ack_o);
    assert_ack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ping_strobe_i |=> !ping_ack_o);

    // R7: genuine request reaches the output in the same cycle
    assert_req_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        esc_req_i |-> esc_active_o);

    // R1: without arming, only a genuine request can escalate
    assert_unarmed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !fired && !esc_req_i) |-> !esc_active_o);

endmodule

// File: tb/ping_loss_watchdog_tb.sv
`timescale 1ns/1ps
module ping_loss_watchdog_tb;
    localparam int unsigned T_NCH = 1, T_CW = 2, T_WC = 1, T_TC = 1, T_MG = 2;
    localparam int THR = T_MG * T_NCH * (T_WC + T_TC) * (2 ** T_CW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ping = 1'b0;
    logic req = 1'b0;
    logic esc, ack;
    int vectors = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    ping_loss_watchdog #(
        .NUM_CH(T_NCH), .CNT_W(T_CW), .WAIT_COUNTS(T_WC),
        .TIMEOUT_COUNTS(T_TC), .MARGIN(T_MG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ping_strobe_i(ping),
        .esc_req_i(req), .esc_active_o(esc), .ping_ack_o(ack)
    );

    task automatic chk(input string rq, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic p);
        ping = p;
        @(posedge clk);
        @(negedge clk);
        ping = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ping = 1'b0; req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; vectors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset esc", esc, 1'b0);
        chk("R1 reset ack", ack, 1'b0);

        for (int j = 0; j < 3 * THR; j++) begin
            cyc(1'b0);
            chk("R1 no pings ever", esc, 1'b0);
        end

        req = 1'b1; #1;
        chk("R7 request unarmed", esc, 1'b1);
        req = 1'b0; #1;
        chk("R7 request released", esc, 1'b0);
        @(negedge clk);

        cyc(1'b1);
        chk("R6 ack after strobe", ack, 1'b1);
        chk("R2 arm no esc", esc, 1'b0);
        cyc(1'b0);
        chk("R6 ack single cycle", ack, 1'b0);
        cyc(1'b1);
        cyc(1'b1);
        chk("R6 ack back to back", ack, 1'b1);
        cyc(1'b0);
        chk("R6 ack drops", ack, 1'b0);

        req = 1'b1; #1;
        chk("R7 request armed", esc, 1'b1);
        req = 1'b0; #1;
        chk("R7 request armed release", esc, 1'b0);
        @(negedge clk);

        // silence after one ping: fire exactly THR edges later (R2, R4, R8)
        do_reset();
        cyc(1'b1);
        for (int j = 1; j <= THR + 3; j++) begin
            cyc(1'b0);
            chk("R4 R8 silence firing edge", esc, (j >= THR));
        end
        for (int j = 0; j < 4; j++) begin
            req = (j % 2 == 1);
            cyc(1'b1);
            chk("R5 sticky after pings", esc, 1'b1);
            chk("R6 ack after fire", ack, 1'b1);
        end
        req = 1'b0;
        for (int j = 0; j < THR + 2; j++) begin
            cyc(1'b0);
            chk("R5 sticky no wrap", esc, 1'b1);
        end
        do_reset();
        chk("R5 reset clears", esc, 1'b0);

        // sweep the spacing between two pings (R3, R4)
        for (int d = 1; d <= THR; d++) begin
            do_reset();
            cyc(1'b1);
            for (int t = 1; t < d; t++) begin
                cyc(1'b0);
                chk("R3 within window", esc, 1'b0);
            end
            cyc(1'b1);
            chk("R4 second ping edge", esc, (d >= THR));
            for (int j = 1; j <= THR + 1; j++) begin
                cyc(1'b0);
                if (d < THR) chk("R3 R4 restarted window", esc, (j >= THR));
                else         chk("R4 late ping no rescue", esc, 1'b1);
            end
        end

        // regular pinging never escalates (R3)
        do_reset();
        for (int k = 0; k < 12; k++) begin
            cyc(1'b1);
            chk("R3 regular ping", esc, 1'b0);
            for (int t = 1; t < THR - 1; t++) begin
                cyc(1'b0);
                chk("R3 regular gap", esc, 1'b0);
            end
        end

        finish_run();
    end
endmodule